// File: doc/BRIEF.md
# Coherency Invalidation and Sync Hub

This block sits beside a shared memory bus and watches the write commands that the bus accepts from several caching masters. For each write it accepts, it broadcasts one invalidation request that covers the written byte range to every master except the writer. It then collects one payload-free acknowledge from each of those masters. Once the last acknowledge is in, it returns a sync notification to the writer only. That notification tells the writer its write can now be seen by every other master.

All traffic uses valid/ready streams, and a transfer happens only in a cycle where both are high. The invalidation payload (address of the first byte, byte count minus one, writer identity, and the flag that excludes the writer) is shared by all masters. Each master has its own valid/ready pair, so one slow master does not hold up delivery to the others. Only one round is in flight at a time, and the write-observation input is back-pressured until the sync of the current round has been taken.

Top module: `coh_sync_hub`

## Requirements
- R1: After reset, wrReady is 1 and every bit of invValid, ackReady and syncValid is 0.
- R2: A write is taken only in a cycle with wrValid and wrReady both high. wrReady is low from the cycle after it is taken until the cycle after the round's sync handshake, and writes offered in that time are ignored.
- R3: The invalidation of a round carries invAll = 1 (meaning "every master but the one in invSource"), invSource equal to the writer, and invAddress and invLength equal to the taken write's address and length (byte count minus one). All four stay stable while any invValid bit is high.
- R4: From the cycle after a write is taken, invValid[i] is 1 for every master i except the writer. Each bit drops in the cycle after its own invReady handshake and does not depend on the other masters. invValid of the writer stays 0.
- R5: ackReady[i] is 1 only after master i's invalidation handshake and until its acknowledge handshake. An ackValid from the writer, or from a master that has not yet taken its invalidation, is not accepted.
- R6: syncValid is one-hot at the writer's bit, with syncSource equal to the writer. It rises in the cycle after the last acknowledge handshake and stays high until syncReady of that bit. It is never high while an acknowledge is still owed.
- R7: Each taken write produces exactly one sync handshake, whatever the order and delay of the acknowledges. After that handshake the hub is idle again, with syncValid 0 and wrReady 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Observed accepted write present |
| wrReady | output | 1 | Hub can start a new round |
| wrSource | input | SRC_W | Index of the writing master |
| wrAddress | input | ADDR_W | First written byte |
| wrLength | input | LEN_W | Written byte count minus one |
| invValid | output | NUM_MASTERS | Per-master invalidation valid |
| invReady | input | NUM_MASTERS | Per-master invalidation ready |
| invAll | output | 1 | 1: all masters but invSource invalidate |
| invAddress | output | ADDR_W | First byte to invalidate |
| invLength | output | LEN_W | Bytes to invalidate minus one |
| invSource | output | SRC_W | Writer index |
| ackValid | input | NUM_MASTERS | Per-master acknowledge valid |
| ackReady | output | NUM_MASTERS | Per-master acknowledge ready |
| syncValid | output | NUM_MASTERS | Per-master sync valid (writer only) |
| syncReady | input | NUM_MASTERS | Per-master sync ready |
| syncSource | output | SRC_W | Master being notified |

## Verification
The bench runs rounds with every master as the writer, under staggered invalidation-ready and acknowledge delays, including rounds where every handshake is immediate. It offers acknowledges too early, holds the writer's acknowledge high all the time, and keeps a new write offered during every round. A hub that raised sync one cycle early or counted an acknowledge that came before its invalidation would show syncValid while the bench still owes acks. A hub that let one master's ready release the others would drop invValid bits that the bench still expects. A hub that reopened wrReady too soon would take the stray write, and the bench would then see a missing or extra sync.

// File: rtl/coh_hub_pkg.sv
`timescale 1ns/1ps
package coh_hub_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // write taken: capture payload, open round
    logic done;   // sync handshake: close round
  } hub_strobe_t;
endpackage

// File: rtl/coh_hub_datapath.sv
`timescale 1ns/1ps
module coh_hub_datapath
  import coh_hub_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int SRC_W       = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hub_strobe_t            stb,
  input  logic [SRC_W-1:0]       wrSource,
  input  logic [ADDR_W-1:0]      wrAddress,
  input  logic [LEN_W-1:0]       wrLength,
  output logic [NUM_MASTERS-1:0] targetMask,
  output logic [NUM_MASTERS-1:0] writerOneHot,
  output logic                   invAll,
  output logic [ADDR_W-1:0]      invAddress,
  output logic [LEN_W-1:0]       invLength,
  output logic [SRC_W-1:0]       invSource,
  output logic [SRC_W-1:0]       syncSource
);
  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  lenQ;
  logic [SRC_W-1:0]  srcQ;
  logic              roundLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      lenQ      <= '0;
      srcQ      <= '0;
      roundLive <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ     <= wrAddress;
        lenQ      <= wrLength;
        srcQ      <= wrSource;
        roundLive <= 1'b1;
      end else if (stb.done) begin
        roundLive <= 1'b0;
      end
    end
  end

  // targets are every master except the incoming writer; writer decoded from capture
  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_dec
    assign targetMask[i]   = (wrSource != SRC_W'(i));
    assign writerOneHot[i] = roundLive && (srcQ == SRC_W'(i));
  end

  assign invAll     = 1'b1;
  assign invAddress = addrQ;
  assign invLength  = lenQ;
  assign invSource  = srcQ;
  assign syncSource = srcQ;

  // R2
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> !roundLive);

  // R7
  done_in_round_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |-> roundLive);
endmodule

// File: rtl/coh_hub_ctrl.sv
`timescale 1ns/1ps
module coh_hub_ctrl
  import coh_hub_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  output logic                   wrReady,
  input  logic [NUM_MASTERS-1:0] targetMask,
  input  logic [NUM_MASTERS-1:0] writerOneHot,
  output logic [NUM_MASTERS-1:0] invValid,
  input  logic [NUM_MASTERS-1:0] invReady,
  input  logic [NUM_MASTERS-1:0] ackValid,
  output logic [NUM_MASTERS-1:0] ackReady,
  output logic [NUM_MASTERS-1:0] syncValid,
  input  logic [NUM_MASTERS-1:0] syncReady,
  output hub_strobe_t            stb
);
  localparam int CNT_W = $clog2(NUM_MASTERS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_SYNC} hub_state_e;

  hub_state_e             state;
  logic [NUM_MASTERS-1:0] invPend;
  logic [NUM_MASTERS-1:0] ackPend;
  logic [CNT_W-1:0]       ackCount;
  logic [NUM_MASTERS-1:0] invFire;
  logic [NUM_MASTERS-1:0] ackFire;
  logic [CNT_W-1:0]       ackTaken;
  logic [CNT_W-1:0]       targetCount;

  always_comb begin
    wrReady   = (state == ST_IDLE);
    invValid  = invPend;
    ackReady  = ackPend & ~invPend;
    syncValid = (state == ST_SYNC) ? writerOneHot : '0;
    invFire   = invValid & invReady;
    ackFire   = ackValid & ackReady;
    stb.load  = wrValid && wrReady;
    stb.done  = (state == ST_SYNC) && |(syncValid & syncReady);
    ackTaken    = '0;
    targetCount = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      ackTaken    = ackTaken + CNT_W'(ackFire[i]);
      targetCount = targetCount + CNT_W'(targetMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      invPend  <= '0;
      ackPend  <= '0;
      ackCount <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (stb.load) begin
            invPend  <= targetMask;
            ackPend  <= targetMask;
            ackCount <= targetCount;
            state    <= (targetCount == '0) ? ST_SYNC : ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          invPend  <= invPend & ~invFire;
          ackPend  <= ackPend & ~ackFire;
          ackCount <= ackCount - ackTaken;
          if (ackCount == ackTaken) state <= ST_SYNC;
        end
        ST_SYNC: begin
          if (stb.done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  sync_after_acks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|syncValid) |-> (ackPend == '0) && (invPend == '0));

  // R6
  sync_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(syncValid));

  // R4
  writer_no_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invValid & writerOneHot) == '0);

  // R7
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackCount == CNT_W'($countones(ackPend)));

  // R4
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(invValid & ~invReady)) |=> (|invValid));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !wrReady);
endmodule

// File: rtl/coh_sync_hub.sv
`timescale 1ns/1ps
module coh_sync_hub
  import coh_hub_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int SRC_W       = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  output logic                   wrReady,
  input  logic [SRC_W-1:0]       wrSource,
  input  logic [ADDR_W-1:0]      wrAddress,
  input  logic [LEN_W-1:0]       wrLength,
  output logic [NUM_MASTERS-1:0] invValid,
  input  logic [NUM_MASTERS-1:0] invReady,
  output logic                   invAll,
  output logic [ADDR_W-1:0]      invAddress,
  output logic [LEN_W-1:0]       invLength,
  output logic [SRC_W-1:0]       invSource,
  input  logic [NUM_MASTERS-1:0] ackValid,
  output logic [NUM_MASTERS-1:0] ackReady,
  output logic [NUM_MASTERS-1:0] syncValid,
  input  logic [NUM_MASTERS-1:0] syncReady,
  output logic [SRC_W-1:0]       syncSource
);
  hub_strobe_t            stb;
  logic [NUM_MASTERS-1:0] targetMask;
  logic [NUM_MASTERS-1:0] writerOneHot;

  coh_hub_ctrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk, .rstN, .wrValid, .wrReady,
    .targetMask, .writerOneHot,
    .invValid, .invReady, .ackValid, .ackReady,
    .syncValid, .syncReady, .stb
  );

  coh_hub_datapath #(
    .NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SRC_W(SRC_W)
  ) u_dp (
    .clk, .rstN, .stb, .wrSource, .wrAddress, .wrLength,
    .targetMask, .writerOneHot,
    .invAll, .invAddress, .invLength, .invSource, .syncSource
  );

  // R3
  payload_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|invValid) && $past(|invValid)) |-> ($stable(invAddress) && $stable(invLength)
                                            && $stable(invSource) && invAll));
endmodule

// File: tb/tb_coh_sync_hub.sv
`timescale 1ns/1ps
module tb_coh_sync_hub;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int SW = 2;
  localparam int ROUNDS = 28;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrValid;
  logic          wrReady;
  logic [SW-1:0] wrSource;
  logic [AW-1:0] wrAddress;
  logic [LW-1:0] wrLength;
  logic [N-1:0]  invValid, invReady, ackValid, ackReady, syncValid, syncReady;
  logic          invAll;
  logic [AW-1:0] invAddress;
  logic [LW-1:0] invLength;
  logic [SW-1:0] invSource, syncSource;

  int checks = 0;
  int errors = 0;
  int syncCount = 0;

  always #10 clk = ~clk;

  coh_sync_hub #(.NUM_MASTERS(N), .ADDR_W(AW), .LEN_W(LW), .SRC_W(SW)) dut (
    .clk, .rstN, .wrValid, .wrReady, .wrSource, .wrAddress, .wrLength,
    .invValid, .invReady, .invAll, .invAddress, .invLength, .invSource,
    .ackValid, .ackReady, .syncValid, .syncReady, .syncSource
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runRound(input int r);
    int src = r % N;
    logic [AW-1:0] addr = AW'(r * 16'h1357 + 3);
    logic [LW-1:0] len  = LW'((r * 37) % 256);
    int invDly[N];
    int ackDly[N];
    bit invDone[N];
    bit ackDone[N];
    int syncDly = r % 3;
    int syncWait = 0;
    int cyc = 0;
    bit finished = 0;
    for (int i = 0; i < N; i++) begin
      invDly[i] = (r < 4) ? 0 : (i * 3 + r * 2) % 5;
      ackDly[i] = (r < 4) ? 0 : (i * 5 + r * 3) % 9;
      invDone[i] = (i == src);
      ackDone[i] = (i == src);
    end
    chk(wrReady == 1'b1, "R2 ready at round start", 32'(wrReady), 1);
    wrValid = 1'b1; wrSource = SW'(src); wrAddress = addr; wrLength = len;
    invReady = '0; ackValid = '0; syncReady = '0;
    @(posedge clk); @(negedge clk);
    // stray write kept on offer through the round
    wrSource = SW'((src + 1) % N); wrAddress = ~addr; wrLength = ~len;
    while (!finished && cyc < 300) begin
      logic [N-1:0] expInv, expAck, expSync;
      bit allAcked = 1;
      bit syncFire;
      bit invF[N];
      bit ackF[N];
      for (int i = 0; i < N; i++) begin
        expInv[i] = !invDone[i];
        expAck[i] = invDone[i] && !ackDone[i];
        if (!ackDone[i]) allAcked = 0;
      end
      expSync = allAcked ? N'(1 << src) : '0;
      chk(invValid == expInv, "R4 invValid", 32'(invValid), 32'(expInv));
      chk(ackReady == expAck, "R5 ackReady", 32'(ackReady), 32'(expAck));
      chk(syncValid == expSync, "R6 syncValid", 32'(syncValid), 32'(expSync));
      chk(wrReady == 1'b0, "R2 busy", 32'(wrReady), 0);
      if (|expInv) begin
        chk(invAll == 1'b1, "R3 invAll", 32'(invAll), 1);
        chk(invAddress == addr, "R3 invAddress", 32'(invAddress), 32'(addr));
        chk(invLength == len, "R3 invLength", 32'(invLength), 32'(len));
        chk(invSource == SW'(src), "R3 invSource", 32'(invSource), src);
      end
      if (allAcked)
        chk(syncSource == SW'(src), "R6 syncSource", 32'(syncSource), src);
      for (int i = 0; i < N; i++) begin
        invReady[i] = (cyc >= invDly[i]);
        ackValid[i] = (i == src) ? 1'b1 : (cyc >= ackDly[i]);
        invF[i] = expInv[i] && invReady[i];
        ackF[i] = expAck[i] && ackValid[i];
      end
      syncReady = (allAcked && syncWait >= syncDly) ? '1 : '0;
      syncFire = allAcked && (syncWait >= syncDly);
      if (allAcked) syncWait++;
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (invF[i]) invDone[i] = 1;
        if (ackF[i]) ackDone[i] = 1;
      end
      if (syncFire) begin
        syncCount++;
        finished = 1;
      end
      cyc++;
    end
    chk(finished, "R7 round completed", 32'(finished), 1);
    chk(syncValid == '0, "R7 sync dropped after handshake", 32'(syncValid), 0);
    chk(wrReady == 1'b1, "R7 idle after sync", 32'(wrReady), 1);
    invReady = '0; ackValid = '0; syncReady = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrSource = '0; wrAddress = '0; wrLength = '0;
    invReady = '1; ackValid = '1; syncReady = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    invReady = '0; ackValid = '0; syncReady = '0;
    @(negedge clk);
    // R1 reset state
    chk(wrReady == 1'b1, "R1 wrReady", 32'(wrReady), 1);
    chk(invValid == '0, "R1 invValid", 32'(invValid), 0);
    chk(ackReady == '0, "R1 ackReady", 32'(ackReady), 0);
    chk(syncValid == '0, "R1 syncValid", 32'(syncValid), 0);
    // R5 acks with nothing pending stay unaccepted
    ackValid = '1;
    @(posedge clk); @(negedge clk);
    chk(ackReady == '0, "R5 idle ack ignored", 32'(ackReady), 0);
    chk(syncValid == '0, "R5 idle ack gives no sync", 32'(syncValid), 0);
    ackValid = '0;
    for (int r = 0; r < ROUNDS; r++) runRound(r);
    wrValid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(syncCount == ROUNDS, "R7 sync count", 32'(syncCount), ROUNDS);
    chk(invValid == '0 && syncValid == '0, "R7 quiet at end", 32'({invValid, syncValid}), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule